// File: doc/BRIEF.md
# Pass-Scaled Input Shifter and Rounder

This block conditions each incoming complex sample before it reaches the arithmetic core of a pass-based transform engine. The real and imaginary words travel as two parallel lanes with the same scaling. Each accepted word is shifted right arithmetically by a pass-wide amount between 0 and 16 positions. It is then rounded half-up, using the bit that falls just below the retained least significant bit, and narrowed to the output width with saturation.

The shift amount is the scale factor measured at the end of the previous pass. It is captured when a pass opens, and it applies from the opening sample onward. A later change on the request pins leaves the current pass alone. Two zero controls support zero filling and zero padding. One replaces the accepted input with zero. The other forces the produced output to zero. Results appear one clock after the sample is accepted, with a matching valid flag.

Top module: `pass_input_conditioner`

## Requirements
- R1: An accepted sample produces out_valid high exactly one clock edge later, with its results on out_re and out_im in that same cycle.
- R2: For an effective shift s, the output equals floor((x + 2^(s-1)) / 2^s) for s > 0, which is an arithmetic right shift plus one when the bit at position s-1 of x is set. For s = 0 the output equals x.
- R3: When zero_in is high on an accepted sample, that sample is treated as zero, and the output is zero for every shift amount.
- R4: When zero_out is high on an accepted sample, the output is zero whatever the input and the shift.
- R5: The output never wraps. A non-negative input never yields a negative output, and results beyond the output range saturate to the extreme value of matching sign. For example, 0x7FFFFF at shift 0 stays 0x7FFFFF, and at shift 1 it becomes 0x400000.
- R6: shift_req is captured on the cycle pass_start is high, and it already applies to the sample of that cycle. Changes of shift_req on cycles without pass_start have no effect on the outputs.
- R7: A captured request greater than 16 acts as a shift of 16.
- R8: Samples are accepted from the pass_start cycle through the pass_stop cycle, both included. A pass_start and pass_stop in the same cycle form a one-sample pass. An in_valid outside a pass produces no out_valid.
- R9: The real and imaginary lanes use the same shift and the same zero controls, and each matches R2 on its own input.
- R10: After reset, out_valid, out_re and out_im are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pass_start | input | 1 | Opens a pass and captures shift_req |
| pass_stop | input | 1 | Last sample cycle of the pass |
| shift_req | input | 5 | Requested right shift for the pass (clamped to 16) |
| in_valid | input | 1 | Input sample present |
| zero_in | input | 1 | Substitute zero for the input sample |
| zero_out | input | 1 | Force the output sample to zero |
| in_re | input | 24 | Real input word, two's complement |
| in_im | input | 24 | Imaginary input word, two's complement |
| out_valid | output | 1 | Output sample present |
| out_re | output | 24 | Shifted and rounded real word |
| out_im | output | 24 | Shifted and rounded imaginary word |

## Verification
Every request value from 0 to 31 opens its own pass. Each pass then carries single-bit and two-bit words, their complements, the four range extremes and scrambled words, so a round-up or a truncation at every bit position below the kept LSB separates correct rounding from plain truncation, and values of 17 and above show whether clamping happens. The two lanes always carry different words, which exposes any swap or shared-lane mistake. Directed passes change the request in mid-pass, send samples before a start, after a stop and after a one-cycle pass, and combine the zero controls with full-scale words, so capture, window and forcing faults each give a distinct wrong output.

// File: rtl/pic_pkg.sv
package pic_pkg;

   // Per-sample control bundle handed from the pass control to the lanes.
   typedef struct packed {
      logic take;   // sample accepted this cycle
      logic zin;    // replace input with zero
      logic zout;   // force output to zero
   } pic_ctl_t;

   // Number of bits needed to hold values 0..n.
   function automatic int unsigned cnt_bits(input int unsigned n);
      int unsigned b;
      b = 1;
      while ((32'd1 << b) <= n) b++;
      return b;
   endfunction

endpackage

// File: rtl/pic_pass_ctrl.sv
module pic_pass_ctrl #(
   parameter int REQ_W     = 5,
   parameter int MAX_SHIFT = 16,
   parameter int SH_W      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass_start,
   input  logic             pass_stop,
   input  logic [REQ_W-1:0] shift_req,
   output logic             accept,
   output logic [SH_W-1:0]  shift_eff
);

   logic [SH_W-1:0] req_clamped;
   logic [SH_W-1:0] shift_q;
   logic            in_pass_q;

   // Clamp only when the request field can express values above the limit.
   generate
      if ((2 ** REQ_W) - 1 > MAX_SHIFT) begin : g_clamp
         always_comb begin
            if (32'(shift_req) > 32'(MAX_SHIFT))
               req_clamped = SH_W'(MAX_SHIFT);
            else
               req_clamped = SH_W'(shift_req);
         end
      end else begin : g_direct
         always_comb req_clamped = SH_W'(shift_req);
      end
   endgenerate

   // The opening sample already uses the freshly requested amount.
   assign shift_eff = pass_start ? req_clamped : shift_q;
   assign accept    = pass_start | in_pass_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q   <= '0;
         in_pass_q <= 1'b0;
      end else begin
         if (pass_start) shift_q <= req_clamped;
         if (pass_start)      in_pass_q <= ~pass_stop;
         else if (pass_stop)  in_pass_q <= 1'b0;
      end
   end

   // R6: without a start the captured amount never moves
   a_r6_shift_held: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_start |=> $stable(shift_q));

   // R7: the captured amount stays within the shifter's reach
   a_r7_shift_limit: assert property (@(posedge clk) disable iff (!rst_n)
      32'(shift_q) <= 32'(MAX_SHIFT));

   // R8: a stop without a new start closes the window
   a_r8_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_stop && !pass_start) |=> !in_pass_q);

endmodule

// File: rtl/pic_lane.sv
module pic_lane #(
   parameter int IN_W     = 24,
   parameter int OUT_W    = 24,
   parameter int SH_W     = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  pic_pkg::pic_ctl_t       ctl,
   input  logic [SH_W-1:0]         shift,
   input  logic signed [IN_W-1:0]  din,
   output logic signed [OUT_W-1:0] dout
);

   localparam int EXT_W = IN_W - OUT_W + 2;

   logic signed [IN_W-1:0]  x;
   logic signed [IN_W-1:0]  pre;
   logic signed [IN_W-1:0]  kept;
   logic                    rbit;
   logic signed [IN_W:0]    sum;
   logic signed [OUT_W-1:0] res;

   // Shift by s-1 first: the LSB left there is the rounding bit.
   always_comb begin
      x = ctl.zin ? '0 : din;
      if (shift == '0) begin
         pre  = x;
         kept = x;
         rbit = 1'b0;
      end else begin
         pre  = x >>> (shift - 1'b1);
         kept = pre >>> 1;
         rbit = pre[0];
      end
      sum = $signed({kept[IN_W-1], kept}) + $signed({{IN_W{1'b0}}, rbit});
   end

   generate
      if (SATURATE) begin : g_sat
         localparam logic signed [IN_W:0] HI_LIM = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
         localparam logic signed [IN_W:0] LO_LIM = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};
         always_comb begin
            if (sum > HI_LIM)      res = HI_LIM[OUT_W-1:0];
            else if (sum < LO_LIM) res = LO_LIM[OUT_W-1:0];
            else                   res = sum[OUT_W-1:0];
         end
      end else begin : g_wrap
         always_comb res = sum[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dout <= '0;
      else if (ctl.take) dout <= ctl.zout ? '0 : res;
   end

   // R3: a zero-filled sample rounds to zero at any shift
   a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.take && ctl.zin) |=> (dout == '0));

   // R4: zero padding wins over any input
   a_r4_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.take && ctl.zout) |=> (dout == '0));

   // R5: a non-negative input never comes out negative
   a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.take && !ctl.zin && !din[IN_W-1]) |=> !dout[OUT_W-1]);

endmodule

// File: rtl/pass_input_conditioner.sv
module pass_input_conditioner #(
   parameter int IN_W      = 24,
   parameter int OUT_W     = 24,
   parameter int MAX_SHIFT = 16,
   parameter int REQ_W     = 5,
   parameter bit SATURATE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pass_start,
   input  logic             pass_stop,
   input  logic [REQ_W-1:0] shift_req,
   input  logic             in_valid,
   input  logic             zero_in,
   input  logic             zero_out,
   input  logic [IN_W-1:0]  in_re,
   input  logic [IN_W-1:0]  in_im,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_re,
   output logic [OUT_W-1:0] out_im
);

   import pic_pkg::*;

   localparam int SH_W   = int'(cnt_bits(MAX_SHIFT));
   localparam int NLANES = 2;

   generate
      if (OUT_W > IN_W) begin : g_bad_width
         $error("output wider than input is not supported");
      end
      if (MAX_SHIFT >= IN_W) begin : g_bad_shift
         $error("shift limit must be below the input width");
      end
      if ((2 ** REQ_W) - 1 < MAX_SHIFT) begin : g_bad_req
         $error("request field cannot reach the shift limit");
      end
   endgenerate

   logic            accept;
   logic [SH_W-1:0] shift_eff;
   pic_ctl_t        ctl;

   logic signed [IN_W-1:0]  lane_in  [NLANES];
   logic signed [OUT_W-1:0] lane_out [NLANES];

   pic_pass_ctrl #(
      .REQ_W    (REQ_W),
      .MAX_SHIFT(MAX_SHIFT),
      .SH_W     (SH_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pass_start(pass_start),
      .pass_stop (pass_stop),
      .shift_req (shift_req),
      .accept    (accept),
      .shift_eff (shift_eff)
   );

   always_comb begin
      ctl.take = accept & in_valid;
      ctl.zin  = zero_in;
      ctl.zout = zero_out;
   end

   assign lane_in[0] = $signed(in_re);
   assign lane_in[1] = $signed(in_im);

   generate
      for (genvar g = 0; g < NLANES; g++) begin : g_lane
         pic_lane #(
            .IN_W    (IN_W),
            .OUT_W   (OUT_W),
            .SH_W    (SH_W),
            .SATURATE(SATURATE)
         ) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .ctl  (ctl),
            .shift(shift_eff),
            .din  (lane_in[g]),
            .dout (lane_out[g])
         );
      end
   endgenerate

   assign out_re = lane_out[0];
   assign out_im = lane_out[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= accept & in_valid;
   end

   // R1: every output strobe answers an input strobe one edge earlier
   a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   // R8: no output for a sample outside the pass window
   a_r8_outside_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pass_start && !accept) |=> !out_valid);

   // R9: identical inputs give identical outputs on both lanes
   a_r9_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_valid && in_re == in_im) |=> (out_re == out_im));

endmodule

// File: tb/tb_pass_input_conditioner.sv
module tb_pass_input_conditioner;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pass_start = 1'b0, pass_stop = 1'b0;
   logic [4:0]  shift_req = '0;
   logic        in_valid = 1'b0, zero_in = 1'b0, zero_out = 1'b0;
   logic [23:0] in_re = '0, in_im = '0;
   logic        out_valid;
   logic [23:0] out_re, out_im;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   pass_input_conditioner dut (
      .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .pass_stop(pass_stop),
      .shift_req(shift_req), .in_valid(in_valid), .zero_in(zero_in),
      .zero_out(zero_out), .in_re(in_re), .in_im(in_im),
      .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
   );

   always #(CLK_P/2) clk = ~clk;

   // Arithmetic model of R2, R3, R4, R5, R7.
   function automatic logic [23:0] model(input logic [23:0] x, input int req,
                                         input bit zi, input bit zo);
      longint v;
      int s;
      if (zo) return 24'h0;
      v = zi ? 64'sd0 : longint'($signed(x));
      s = (req > 16) ? 16 : req;
      if (s > 0) v = (v + (64'sd1 <<< (s - 1))) >>> s;
      if (v > 64'sd8388607)  v = 64'sd8388607;
      if (v < -64'sd8388608) v = -64'sd8388608;
      return v[23:0];
   endfunction

   function automatic logic [23:0] pat(input int i);
      int k;
      k = i % 64;
      if (k < 4) begin
         case (k)
            0: return 24'h7FFFFF;
            1: return 24'h800000;
            2: return 24'h000000;
            default: return 24'hFFFFFF;
         endcase
      end else if (k < 28) begin
         return (24'h1 << (k - 4)) | (24'h1 << ((k - 4) / 2));
      end else if (k < 52) begin
         return ~((24'h1 << (k - 28)) | (24'h1 << ((k - 28) / 3)));
      end else begin
         return 24'((32'(k) * 32'h9E3779B1) >> 5);
      end
   endfunction

   task automatic check(input bit ok, input string tag, input logic [23:0] act,
                        input logic [23:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive one cycle, then look at the outputs a quarter period after the edge.
   task automatic step(input logic [23:0] re, input logic [23:0] im,
                       input bit v, input bit st, input bit sp,
                       input bit zi, input bit zo, input int req,
                       input bit exp_v, input int exp_s, input string tag);
      logic [23:0] er, ei;
      @(negedge clk);
      in_re = re; in_im = im; in_valid = v;
      pass_start = st; pass_stop = sp;
      zero_in = zi; zero_out = zo; shift_req = 5'(req);
      @(posedge clk);
      #(CLK_P/4);
      check(out_valid == exp_v, {"R1 ", tag, " valid"}, 24'(out_valid), 24'(exp_v));
      if (exp_v) begin
         er = model(re, exp_s, zi, zo);
         ei = model(im, exp_s, zi, zo);
         check(out_re == er, {tag, " R9 re"}, out_re, er);
         check(out_im == ei, {tag, " R9 im"}, out_im, ei);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0; pass_start = 1'b0; pass_stop = 1'b0;
      zero_in = 1'b0; zero_out = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      // R10: reset state
      check(out_valid == 1'b0, "R10 valid", 24'(out_valid), 24'h0);
      check(out_re == 24'h0, "R10 re", out_re, 24'h0);
      check(out_im == 24'h0, "R10 im", out_im, 24'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 and R7: sweep every request with many words per pass.
      for (int req = 0; req < 32; req++) begin
         for (int i = 0; i < 64; i++) begin
            step(pat(i + req), pat(i + req + 23), 1'b1, i == 0, i == 63,
                 1'b0, 1'b0, (i == 0) ? req : 0, 1'b1, req,
                 (req > 16) ? "R7 clamp" : "R2 sweep");
         end
         idle();
      end

      // R8: outside any pass nothing is accepted.
      step(24'h123456, 24'h654321, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1'b0, 3, "R8 before start");

      // R6: capture on start; mid-pass request changes are ignored.
      step(24'h0000FF, 24'hFFFF01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4, 1'b1, 4, "R6 start cycle");
      step(24'h00012B, 24'hFFFED5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9, 1'b1, 4, "R6 changed req");
      step(24'h7FFFFF, 24'h800001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 31, 1'b1, 4, "R6 changed req");
      step(24'h000000, 24'h000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b0, 4, "R8 gap no valid");
      step(24'h000018, 24'hFFFFE8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b1, 4, "R8 stop cycle");
      step(24'h000018, 24'hFFFFE8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 4, "R8 after stop");

      // R8: one-sample pass.
      step(24'h000005, 24'hFFFFFB, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1, "R8 single pass");
      step(24'h000005, 24'hFFFFFB, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1, "R8 after single");

      // R3 and R4: zero controls with full-scale words.
      step(24'h7FFFFF, 24'h800000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b1, 0, "R3 fill s0");
      step(24'h800000, 24'h7FFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b1, 0, "R4 pad s0");
      step(24'h555555, 24'hAAAAAA, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b1, 0, "R4 both");
      step(24'h7FFFFF, 24'h800000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b1, 0, "R5 max s0");
      idle();
      step(24'h7FFFFF, 24'h800000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16, 1'b1, 16, "R3 fill s16");
      step(24'h7FFFFF, 24'h800000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b1, 16, "R4 pad s16");

      // R5: rounding up near full scale, explicit expected values.
      step(24'h7FFFFF, 24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1, "R5 round s1");
      check(out_re == 24'h400000, "R5 full scale s1", out_re, 24'h400000);
      check(out_im == 24'h000000, "R2 minus one s1", out_im, 24'h000000);
      step(24'hFFFFFD, 24'h000003, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1, "R2 three s1");
      check(out_re == 24'hFFFFFF, "R2 minus three s1", out_re, 24'hFFFFFF);
      check(out_im == 24'h000002, "R2 plus three s1", out_im, 24'h000002);
      idle();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule